// File: doc/BRIEF.md
# Hot Page Detection Counter Unit

This unit sits beside the home memory controller of one node and looks for pages that would be worth migrating or replicating. Every cache miss that reaches the home arrives as an event carrying the page index, the CPU that missed and a kind bit that tells a miss from a writeback. Only one miss in N is counted. Each counted miss bumps a saturating per-page, per-CPU counter. When that counter climbs to the trigger level, the page index is appended to a short queue of hot pages. Writebacks set a per-page write mark and can optionally wipe that page's counters.

Software drains the hot-page queue through a pop port and is interrupted once enough pages are waiting. A timer starts a sweep at a programmed interval. The sweep clears one page row per cycle so that old history decays. The events enter through a valid/ready channel, and the unit holds `ev_ready` low only while a sweep is running. The pop port has the head visible on `pop_data` whenever `pop_valid` is high. An empty queue reads as all ones.

Top module: `hot_page_detector`

## Requirements
- R1: After reset the registers read CTRL=0, SAMPLE=10, TRIGGER=9, IRQ_LEVEL=2. The queue is empty: `pop_valid`=0, `pop_data`=0xFFFFFFFF, `irq`=0 and `ev_ready`=1.
- R2: While CTRL bit0 (enable) is 0, accepted events change no counter, no write mark and no sampling phase.
- R3: Only every N-th enabled miss event (N = SAMPLE register, global across pages and CPUs, first counted miss is the N-th) increments the addressed counter. N of 0 or 1 counts every miss.
- R4: A counter never exceeds its cap. The cap is 15 when CTRL bit1 (narrow) is set and 255 otherwise, and a counted miss at the cap leaves the counter at the cap.
- R5: A counted miss that takes a counter from below TRIGGER to TRIGGER or above appends the page index, zero-extended, to the tail of the queue. A TRIGGER of 0 never fires.
- R6: A page already waiting in the queue is not appended again. A hot page is dropped while the queue holds 10 entries.
- R7: `pop_data` shows the head (oldest) entry or 0xFFFFFFFF when empty. A cycle with `pop_ready` and `pop_valid` high removes the head, and `pop_ready` on an empty queue has no effect.
- R8: `irq` is high exactly when IRQ_LEVEL is nonzero and the queue holds at least IRQ_LEVEL entries.
- R9: An enabled writeback event (`ev_wb`=1) sets the page's write mark and does not advance the sampling phase. If CTRL bit2 (zero-on-write) is set, it also clears every CPU counter of that page.
- R10: With the SWEEP register nonzero and enable set, a sweep starts every SWEEP cycles. It clears one page row (all counters and the write mark) per cycle for 16 cycles with `ev_ready` low, and it does not touch the queue.
- R11: Writing register 5 selects a page (bits 15:0) and CPU (bits 31:16). Register 6 then reads the write mark in bit 8 and the counter in bits 7:0.
- R12: An event takes effect only in a cycle where `ev_valid` and `ev_ready` are both high. An event held during a sweep is applied exactly once after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Event accepted this cycle; low during a sweep |
| ev_page | input | $clog2(NUM_PAGES) | Page index of the event |
| ev_cpu | input | $clog2(NUM_CPUS) | CPU index of the event |
| ev_wb | input | 1 | 1 = writeback, 0 = miss |
| pop_ready | input | 1 | Request to remove the head entry |
| pop_valid | output | 1 | Queue not empty |
| pop_data | output | 32 | Head page index or 0xFFFFFFFF |
| irq | output | 1 | Hot-page interrupt |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address (0 CTRL, 1 SAMPLE, 2 TRIGGER, 3 IRQ_LEVEL, 4 SWEEP, 5 probe select, 6 probe data) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |

## Verification
Directed sequences first drive misses with the enable off, then with sampling at 1 and at 3, with writebacks mixed in. This separates counting from sampling and shows that writebacks leave the phase alone. Long runs of misses to one entry in narrow and wide modes probe the two saturation caps. A run that triggers the same page from two CPUs and then floods eleven pages separates duplicate suppression from the full-queue drop and checks pop order. A random mix of misses, writebacks, pops and probes over a small page set then exercises queue churn, the interrupt level and sampling together. The sweep is watched through the length of the `ev_ready` low window, and through an event held across it.

// File: rtl/hpd_pkg.sv
package hpd_pkg;
  localparam int REG_W = 32;
  localparam int CTR_W = 8;
  localparam int SWP_W = 16;

  localparam logic [2:0] A_CTRL   = 3'd0;
  localparam logic [2:0] A_SAMPLE = 3'd1;
  localparam logic [2:0] A_TRIG   = 3'd2;
  localparam logic [2:0] A_IRQ    = 3'd3;
  localparam logic [2:0] A_SWEEP  = 3'd4;
  localparam logic [2:0] A_PSEL   = 3'd5;
  localparam logic [2:0] A_PDATA  = 3'd6;

  localparam logic [7:0] DEF_SAMPLE = 8'd10;
  localparam logic [7:0] DEF_TRIG   = 8'd9;
  localparam logic [7:0] DEF_IRQ    = 8'd2;

  typedef struct packed {
    logic             enable;
    logic             narrow;
    logic             zero_on_wr;
    logic [7:0]       sample_n;
    logic [7:0]       trigger;
    logic [7:0]       irq_level;
    logic [SWP_W-1:0] sweep_ivl;
  } cfg_t;
endpackage

// File: rtl/hpd_cfg_regs.sv
module hpd_cfg_regs
  import hpd_pkg::*;
#(
  parameter int PG_W      = 4,
  parameter int CPU_W     = 2,
  parameter int DEF_SWEEP = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [2:0]       addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output cfg_t             cfg,
  output logic [PG_W-1:0]  psel_page,
  output logic [CPU_W-1:0] psel_cpu,
  input  logic [CTR_W:0]   probe_data
);
  logic unused_wdata;
  assign unused_wdata = ^wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg.enable     <= 1'b0;
      cfg.narrow     <= 1'b0;
      cfg.zero_on_wr <= 1'b0;
      cfg.sample_n   <= DEF_SAMPLE;
      cfg.trigger    <= DEF_TRIG;
      cfg.irq_level  <= DEF_IRQ;
      cfg.sweep_ivl  <= SWP_W'(DEF_SWEEP);
      psel_page      <= '0;
      psel_cpu       <= '0;
    end else if (wr) begin
      case (addr)
        A_CTRL: begin
          cfg.enable     <= wdata[0];
          cfg.narrow     <= wdata[1];
          cfg.zero_on_wr <= wdata[2];
        end
        A_SAMPLE: cfg.sample_n  <= wdata[7:0];
        A_TRIG:   cfg.trigger   <= wdata[7:0];
        A_IRQ:    cfg.irq_level <= wdata[7:0];
        A_SWEEP:  cfg.sweep_ivl <= wdata[SWP_W-1:0];
        A_PSEL: begin
          psel_page <= wdata[PG_W-1:0];
          psel_cpu  <= wdata[16 +: CPU_W];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:   rdata[2:0] = {cfg.zero_on_wr, cfg.narrow, cfg.enable};
      A_SAMPLE: rdata[7:0] = cfg.sample_n;
      A_TRIG:   rdata[7:0] = cfg.trigger;
      A_IRQ:    rdata[7:0] = cfg.irq_level;
      A_SWEEP:  rdata[SWP_W-1:0] = cfg.sweep_ivl;
      A_PSEL: begin
        rdata[PG_W-1:0]    = psel_page;
        rdata[16 +: CPU_W] = psel_cpu;
      end
      A_PDATA:  rdata[CTR_W:0] = probe_data;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/hpd_sampler.sv
module hpd_sampler (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       miss_fire,
  input  logic       enable,
  input  logic [7:0] sample_n,
  output logic       hit
);
  logic [7:0] phase_q;
  logic       live;

  assign live = miss_fire && enable;
  assign hit  = live && ((sample_n <= 8'd1) || (phase_q >= sample_n - 8'd1));

  always_ff @(posedge clk) begin
    if (!rst_n)    phase_q <= '0;
    else if (live) phase_q <= hit ? 8'd0 : phase_q + 8'd1;
  end

  // R3
  sample_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> phase_q == 8'd0);

  // R3
  sample_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !live |=> $stable(phase_q));
endmodule

// File: rtl/hpd_counter_array.sv
module hpd_counter_array
  import hpd_pkg::*;
#(
  parameter int NUM_PAGES = 16,
  parameter int NUM_CPUS  = 4,
  localparam int PG_W  = $clog2(NUM_PAGES),
  localparam int CPU_W = $clog2(NUM_CPUS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_fire,
  input  logic             ev_wb,
  input  logic [PG_W-1:0]  ev_page,
  input  logic [CPU_W-1:0] ev_cpu,
  input  logic             enable,
  input  logic             narrow,
  input  logic             zero_on_wr,
  input  logic [7:0]       trigger,
  input  logic [SWP_W-1:0] sweep_ivl,
  input  logic             sample_hit,
  input  logic [PG_W-1:0]  probe_page,
  input  logic [CPU_W-1:0] probe_cpu,
  output logic [CTR_W:0]   probe_data,
  output logic             hot_push,
  output logic [PG_W-1:0]  hot_page,
  output logic             sweeping
);
  localparam logic [PG_W-1:0] LAST_PG = PG_W'(NUM_PAGES - 1);

  logic [CTR_W-1:0] ctr_q [NUM_PAGES][NUM_CPUS];
  logic [NUM_PAGES-1:0] wbit_q;

  logic [CTR_W-1:0] cur_val, inc_val, cap_val;
  logic             count_en, mark_en;

  logic [SWP_W-1:0] timer_q;
  logic [PG_W-1:0]  sweep_idx;
  logic             sweep_run, sweep_start;

  // saturating increment of the addressed entry
  assign cap_val  = narrow ? CTR_W'(15) : {CTR_W{1'b1}};
  assign cur_val  = ctr_q[ev_page][ev_cpu];
  assign inc_val  = (cur_val >= cap_val) ? cap_val : cur_val + CTR_W'(1);
  assign count_en = sample_hit && !ev_wb;
  assign mark_en  = ev_fire && ev_wb && enable;

  assign hot_push = count_en && (cur_val < trigger) && (inc_val >= trigger);
  assign hot_page = ev_page;

  assign probe_data = {wbit_q[probe_page], ctr_q[probe_page][probe_cpu]};

  // interval timer that launches a sweep
  assign sweep_run   = enable && (sweep_ivl != '0);
  assign sweep_start = sweep_run && !sweeping && (timer_q >= sweep_ivl - SWP_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timer_q   <= '0;
      sweeping  <= 1'b0;
      sweep_idx <= '0;
    end else begin
      if (!sweep_run || sweep_start) timer_q <= '0;
      else if (!sweeping)            timer_q <= timer_q + SWP_W'(1);

      if (sweep_start) begin
        sweeping <= 1'b1;
      end else if (sweeping) begin
        if (sweep_idx == LAST_PG) begin
          sweeping  <= 1'b0;
          sweep_idx <= '0;
        end else begin
          sweep_idx <= sweep_idx + PG_W'(1);
        end
      end
    end
  end

  // counter and mark storage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NUM_PAGES; p++)
        for (int c = 0; c < NUM_CPUS; c++)
          ctr_q[p][c] <= '0;
      wbit_q <= '0;
    end else if (sweeping) begin
      for (int c = 0; c < NUM_CPUS; c++) ctr_q[sweep_idx][c] <= '0;
      wbit_q[sweep_idx] <= 1'b0;
    end else begin
      if (count_en) ctr_q[ev_page][ev_cpu] <= inc_val;
      if (mark_en) begin
        wbit_q[ev_page] <= 1'b1;
        if (zero_on_wr)
          for (int c = 0; c < NUM_CPUS; c++) ctr_q[ev_page][c] <= '0;
      end
    end
  end

  // R10
  sweep_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_start |=> sweeping && (sweep_idx == '0));

  // R10
  sweep_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sweeping && sweep_idx == LAST_PG) |=> !sweeping);

  // R4
  sat_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && !sweeping && narrow && cur_val <= CTR_W'(15)) |=>
      (ctr_q[$past(ev_page)][$past(ev_cpu)] <= CTR_W'(15)));
endmodule

// File: rtl/hpd_hot_queue.sv
module hpd_hot_queue #(
  parameter int DEPTH = 10,
  parameter int W     = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     push_page,
  input  logic             pop,
  output logic [CNT_W-1:0] count,
  output logic [W-1:0]     head
);
  logic [W-1:0]     ent_q [DEPTH];
  logic [W-1:0]     ent_n [DEPTH];
  logic [CNT_W-1:0] base;
  logic             pop_ok, dup, accept;

  assign pop_ok = pop && (count != '0);
  assign head   = ent_q[0];

  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if ((CNT_W'(i) < count) && (ent_q[i] == push_page) && !(pop_ok && i == 0))
        dup = 1'b1;
  end

  assign accept = push && !dup && ((count < CNT_W'(DEPTH)) || pop_ok);
  assign base   = pop_ok ? count - CNT_W'(1) : count;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      if (pop_ok && i < DEPTH - 1) ent_n[i] = ent_q[i + 1];
      else                         ent_n[i] = ent_q[i];
      if (accept && CNT_W'(i) == base) ent_n[i] = push_page;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else begin
      count <= base + CNT_W'(accept);
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= ent_n[i];
    end
  end

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_W'(DEPTH) && !pop) |=> count == CNT_W'(DEPTH));

  // R7
  pop_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ok && !push) |=> count == $past(count) - CNT_W'(1));

  // R7
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && !push) |=> count == '0);
endmodule

// File: rtl/hot_page_detector.sv
module hot_page_detector
  import hpd_pkg::*;
#(
  parameter int NUM_PAGES = 16,
  parameter int NUM_CPUS  = 4,
  parameter int Q_DEPTH   = 10,
  parameter int DEF_SWEEP = 4096,
  localparam int PG_W  = $clog2(NUM_PAGES),
  localparam int CPU_W = $clog2(NUM_CPUS),
  localparam int CNT_W = $clog2(Q_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_valid,
  output logic             ev_ready,
  input  logic [PG_W-1:0]  ev_page,
  input  logic [CPU_W-1:0] ev_cpu,
  input  logic             ev_wb,
  input  logic             pop_ready,
  output logic             pop_valid,
  output logic [31:0]      pop_data,
  output logic             irq,
  input  logic             cfg_wr,
  input  logic [2:0]       cfg_addr,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata
);
  cfg_t             cfg;
  logic [PG_W-1:0]  psel_page, hot_page, q_head;
  logic [CPU_W-1:0] psel_cpu;
  logic [CTR_W:0]   probe_data;
  logic             sweeping, ev_fire, sample_hit, hot_push, pop_fire;
  logic [CNT_W-1:0] q_count;

  assign ev_ready = !sweeping;
  assign ev_fire  = ev_valid && ev_ready;

  hpd_cfg_regs #(.PG_W(PG_W), .CPU_W(CPU_W), .DEF_SWEEP(DEF_SWEEP)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .cfg(cfg), .psel_page(psel_page), .psel_cpu(psel_cpu),
    .probe_data(probe_data)
  );

  hpd_sampler u_sampler (
    .clk(clk), .rst_n(rst_n), .miss_fire(ev_fire && !ev_wb),
    .enable(cfg.enable), .sample_n(cfg.sample_n), .hit(sample_hit)
  );

  hpd_counter_array #(.NUM_PAGES(NUM_PAGES), .NUM_CPUS(NUM_CPUS)) u_ctrs (
    .clk(clk), .rst_n(rst_n), .ev_fire(ev_fire), .ev_wb(ev_wb),
    .ev_page(ev_page), .ev_cpu(ev_cpu), .enable(cfg.enable),
    .narrow(cfg.narrow), .zero_on_wr(cfg.zero_on_wr), .trigger(cfg.trigger),
    .sweep_ivl(cfg.sweep_ivl), .sample_hit(sample_hit),
    .probe_page(psel_page), .probe_cpu(psel_cpu), .probe_data(probe_data),
    .hot_push(hot_push), .hot_page(hot_page), .sweeping(sweeping)
  );

  hpd_hot_queue #(.DEPTH(Q_DEPTH), .W(PG_W)) u_queue (
    .clk(clk), .rst_n(rst_n), .push(hot_push), .push_page(hot_page),
    .pop(pop_ready), .count(q_count), .head(q_head)
  );

  assign pop_valid = (q_count != '0);
  assign pop_fire  = pop_ready && pop_valid;
  assign pop_data  = pop_valid ? 32'(q_head) : 32'hFFFF_FFFF;
  assign irq       = (cfg.irq_level != 8'd0) && (8'(q_count) >= cfg.irq_level);

  // R7
  last_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_fire && q_count == CNT_W'(1) && !hot_push) |=> !pop_valid);

  // R12
  hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sweeping |-> !hot_push);
endmodule

// File: tb/hot_page_detector_bench.sv
module hot_page_detector_bench;
  localparam int CLK_P = 10;
  localparam int NP = 16;
  localparam int NC = 4;
  localparam int QD = 10;

  logic clk = 0, rst_n = 0;
  logic ev_valid = 0, ev_wb = 0, pop_ready = 0, cfg_wr = 0;
  logic [3:0] ev_page = 0;
  logic [1:0] ev_cpu = 0;
  logic [2:0] cfg_addr = 0;
  logic [31:0] cfg_wdata = 0;
  logic ev_ready, pop_valid, irq;
  logic [31:0] pop_data, cfg_rdata;

  always #(CLK_P/2) clk = ~clk;

  hot_page_detector u_hot_page_detector (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_page(ev_page), .ev_cpu(ev_cpu), .ev_wb(ev_wb), .pop_ready(pop_ready),
    .pop_valid(pop_valid), .pop_data(pop_data), .irq(irq), .cfg_wr(cfg_wr),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  int checks = 0, fails = 0;
  int m_ctr [NP][NC];
  bit m_wb [NP];
  int mq [QD];
  int mcount = 0, m_phase = 0;
  int m_en = 0, m_narrow = 0, m_zow = 0, m_n = 10, m_trig = 9, m_lvl = 2;

  task automatic chk_eq(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model_clear();
    for (int p = 0; p < NP; p++) begin
      m_wb[p] = 0;
      for (int c = 0; c < NC; c++) m_ctr[p][c] = 0;
    end
  endfunction

  function automatic void model_event(int pg, int cpu, bit wb);
    int cap, cur, inc;
    bit hitv, dup;
    if (m_en == 0) return;
    if (wb) begin
      m_wb[pg] = 1;
      if (m_zow != 0) for (int c = 0; c < NC; c++) m_ctr[pg][c] = 0;
      return;
    end
    hitv = (m_n <= 1) || (m_phase >= m_n - 1);
    m_phase = hitv ? 0 : m_phase + 1;
    if (!hitv) return;
    cap = (m_narrow != 0) ? 15 : 255;
    cur = m_ctr[pg][cpu];
    inc = (cur >= cap) ? cap : cur + 1;
    m_ctr[pg][cpu] = inc;
    if (cur < m_trig && inc >= m_trig) begin
      dup = 0;
      for (int i = 0; i < mcount; i++) if (mq[i] == pg) dup = 1;
      if (!dup && mcount < QD) begin
        mq[mcount] = pg;
        mcount++;
      end
    end
  endfunction

  function automatic void model_pop();
    if (mcount == 0) return;
    for (int i = 0; i < QD - 1; i++) mq[i] = mq[i + 1];
    mcount--;
  endfunction

  task automatic cfg_write(int a, int d);
    @(negedge clk);
    cfg_wr = 1; cfg_addr = 3'(a); cfg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic cfg_read(int a, output logic [31:0] v);
    @(negedge clk);
    cfg_addr = 3'(a);
    #1 v = cfg_rdata;
  endtask

  task automatic set_ctrl(int en, int nar, int zow);
    cfg_write(0, en | (nar << 1) | (zow << 2));
    m_en = en; m_narrow = nar; m_zow = zow;
  endtask

  task automatic send_event(int pg, int cpu, bit wb);
    bit rdy;
    bit fired;
    @(negedge clk);
    ev_valid = 1; ev_page = 4'(pg); ev_cpu = 2'(cpu); ev_wb = wb;
    fired = 0;
    while (!fired) begin
      #1 rdy = ev_ready;
      @(posedge clk);
      if (rdy) fired = 1;
      else @(negedge clk);
    end
    model_event(pg, cpu, wb);
    @(negedge clk);
    ev_valid = 0;
  endtask

  task automatic probe_chk(int pg, int cpu, string tag);
    logic [31:0] v;
    cfg_write(5, (cpu << 16) | pg);
    cfg_read(6, v);
    chk_eq(tag, v, 32'((m_wb[pg] ? 256 : 0) + m_ctr[pg][cpu]));
  endtask

  task automatic do_pop(string tag);
    logic [31:0] exp;
    @(negedge clk);
    pop_ready = 1;
    #1 exp = (mcount > 0) ? 32'(mq[0]) : 32'hFFFF_FFFF;
    chk_eq(tag, pop_data, exp);
    @(posedge clk);
    #1 pop_ready = 0;
    model_pop();
  endtask

  task automatic irq_chk(string tag);
    @(negedge clk);
    #1 chk_eq(tag, {31'b0, irq}, {31'b0, (m_lvl != 0 && mcount >= m_lvl)});
    chk_eq(tag, {31'b0, pop_valid}, {31'b0, mcount > 0});
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int lo;
    void'($urandom(32'd20240));
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1 reset state
    cfg_read(0, v); chk_eq("R1 ctrl", v, 0);
    cfg_read(1, v); chk_eq("R1 sample", v, 10);
    cfg_read(2, v); chk_eq("R1 trigger", v, 9);
    cfg_read(3, v); chk_eq("R1 irq level", v, 2);
    chk_eq("R1 pop_data", pop_data, 32'hFFFF_FFFF);
    chk_eq("R1 pop_valid", {31'b0, pop_valid}, 0);
    chk_eq("R1 irq", {31'b0, irq}, 0);
    chk_eq("R1 ev_ready", {31'b0, ev_ready}, 1);
    cfg_write(4, 0);

    // R2 disabled events ignored
    cfg_write(1, 1); m_n = 1;
    for (int i = 0; i < 3; i++) send_event(1, 0, 0);
    send_event(1, 0, 1);
    probe_chk(1, 0, "R2 disabled no count");

    // R3 sampling, R9 writeback leaves phase alone
    set_ctrl(1, 0, 0);
    cfg_write(1, 3); m_n = 3;
    for (int i = 0; i < 6; i++) send_event(2, 1, 0);
    probe_chk(2, 1, "R3 one in three counted");
    send_event(2, 0, 1);
    for (int i = 0; i < 3; i++) send_event(2, 1, 0);
    probe_chk(2, 1, "R3 R9 wb skips phase");

    // R4 saturation caps
    cfg_write(1, 1); m_n = 1;
    cfg_write(2, 0); m_trig = 0;
    set_ctrl(1, 1, 0);
    for (int i = 0; i < 20; i++) send_event(3, 2, 0);
    probe_chk(3, 2, "R4 narrow cap 15");
    set_ctrl(1, 0, 0);
    for (int i = 0; i < 245; i++) send_event(3, 2, 0);
    probe_chk(3, 2, "R4 wide cap 255");

    // R5 R6 R7 R8 queue behaviour
    cfg_write(2, 2); m_trig = 2;
    send_event(4, 0, 0); send_event(4, 0, 0);
    irq_chk("R5 first hot page");
    send_event(4, 1, 0); send_event(4, 1, 0);
    send_event(4, 0, 0);
    for (int p = 5; p <= 14; p++) begin
      send_event(p, 0, 0); send_event(p, 0, 0);
    end
    irq_chk("R8 irq at level");
    cfg_write(3, 0); m_lvl = 0;
    irq_chk("R8 level zero off");
    cfg_write(3, 2); m_lvl = 2;
    for (int i = 0; i < 11; i++) do_pop("R6 R7 pop order and drop");
    irq_chk("R7 empty after drain");

    // R9 zero on write
    set_ctrl(1, 0, 1);
    send_event(5, 0, 1);
    probe_chk(5, 0, "R9 zero on write");
    set_ctrl(1, 0, 0);
    send_event(6, 0, 1);
    probe_chk(6, 0, "R9 mark only");

    // R10 sweep, R12 held event
    cfg_write(2, 0); m_trig = 0;
    cfg_write(4, 20);
    lo = 0;
    for (int i = 0; i < 200 && ev_ready; i++) @(negedge clk);
    while (!ev_ready && lo < 100) begin lo++; @(negedge clk); end
    chk_eq("R10 sweep length", lo, NP);
    model_clear();
    for (int i = 0; i < 200 && ev_ready; i++) @(negedge clk);
    send_event(7, 3, 0);
    cfg_write(4, 0);
    probe_chk(7, 3, "R12 held event applied once");
    probe_chk(3, 2, "R10 sweep cleared counter");
    probe_chk(5, 0, "R10 sweep cleared mark");
    cfg_read(5, v); chk_eq("R11 select readback", v, (0 << 16) | 5);

    // random mix
    cfg_write(1, 2); m_n = 2;
    cfg_write(2, 3); m_trig = 3;
    cfg_write(3, 3); m_lvl = 3;
    for (int it = 0; it < 400; it++) begin
      int r, pg, cpu;
      r = $urandom % 10; pg = $urandom % NP; cpu = $urandom % NC;
      if (r < 2) do_pop("R7 random pop");
      else if (r == 2) probe_chk(pg, cpu, "R11 random probe");
      else if (r == 3) send_event(pg, cpu, 1);
      else send_event(pg, cpu, 0);
      if (it % 4 == 0) irq_chk("R8 random irq");
    end
    for (int i = 0; i <= QD; i++) do_pop("R5 final drain");
    finish_run();
  end
endmodule